// File: doc/BRIEF.md
# Processor Status Word Unit

This block holds the eight-bit status word of a small processor core. Each cycle it can take new arithmetic flags from the ALU, with a separate enable for each flag, so every instruction changes only the flags it defines. The sign flag is never stored on its own: it is always rebuilt from the negative and overflow flags.

A transfer bit gives single-bit moves between registers. A bit-store request copies one chosen bit of a register into the transfer bit. A bit-load request produces a copy of a register with one chosen bit replaced by the transfer bit. The interrupt controller sets and clears the global interrupt enable. The I/O bus can overwrite the whole word with one byte write at the block's I/O address, and a bus write has priority over every other source in the same cycle.

Top module: `status_word_unit`

## Requirements
- R1: After a synchronous active-low reset, all eight bits of `flags` are 0.
- R2: Bit positions from 7 down to 0 are: interrupt enable, transfer, half-carry, sign, overflow, negative, zero, carry. The sign bit (4) always equals negative (2) XOR overflow (3).
- R3: With `upd_n` high, bit 2 takes `alu_res[7]`. With `upd_z` high, bit 1 is set only when all bits of `alu_res` are zero, and is cleared otherwise.
- R4: With `upd_c`, `upd_h` or `upd_v` high, bit 0, bit 5 or bit 3 takes `alu_cout`, `alu_hcout` or `alu_ovf` respectively. A flag whose enable is low keeps its value.
- R5: With `bst_req` high, bit 6 takes `bst_src[bit_sel]` at the next clock edge.
- R6: `bld_out` equals `bld_src` with bit `bit_sel` replaced by the current bit 6, with no clock delay.
- R7: `int_clr` clears bit 7 and `int_set` sets it. When both are high in the same cycle, the clear wins.
- R8: `io_we` high with `io_addr` = 0x3F loads `io_wdata` into bits 7, 6, 5, 3, 2, 1 and 0. Bit 4 becomes `io_wdata[2]` XOR `io_wdata[3]`. This write overrides every flag update, bit-store and interrupt request in the same cycle.
- R9: A bus write to any other address leaves `flags` unchanged.
- R10: In a cycle with no enable, request or matching write, `flags` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_res | input | 8 | ALU result byte |
| alu_cout | input | 1 | ALU carry out |
| alu_hcout | input | 1 | ALU carry out of the low nibble |
| alu_ovf | input | 1 | ALU two's complement overflow |
| upd_c | input | 1 | Update the carry flag |
| upd_z | input | 1 | Update the zero flag |
| upd_n | input | 1 | Update the negative flag |
| upd_v | input | 1 | Update the overflow flag |
| upd_h | input | 1 | Update the half-carry flag |
| bst_req | input | 1 | Copy a register bit into the transfer bit |
| bst_src | input | 8 | Register value for bit-store |
| bld_src | input | 8 | Register value for bit-load |
| bit_sel | input | 3 | Bit index for bit-store and bit-load |
| int_set | input | 1 | Set the global interrupt enable |
| int_clr | input | 1 | Clear the global interrupt enable |
| io_we | input | 1 | I/O bus write strobe |
| io_addr | input | 6 | I/O bus address |
| io_wdata | input | 8 | I/O bus write data |
| flags | output | 8 | Status word |
| bld_out | output | 8 | Bit-load result |

## Verification
The clocked properties assume that every input is at a known 0 or 1 on each rising edge after reset, and that `bit_sel` always selects a bit that exists. The stimulus changes inputs only just after a falling edge and returns every request to 0 after each step. Expected values therefore depend only on the inputs present at a single rising edge. The stimulus deliberately raises the interrupt set and clear together, and a bus write together with flag updates, to cover the two precedence rules.

// File: rtl/sw_pkg.sv
// Package sw_pkg
// Shared constants for the status word unit: word width, bit positions
// of each flag (fixed, the core decodes them) and the I/O bus address.
package sw_pkg;
    localparam int SW_W   = 8;
    localparam int POS_C  = 0;
    localparam int POS_Z  = 1;
    localparam int POS_N  = 2;
    localparam int POS_V  = 3;
    localparam int POS_S  = 4;
    localparam int POS_H  = 5;
    localparam int POS_T  = 6;
    localparam int POS_I  = 7;
    localparam int IO_AW  = 6;
    localparam logic [IO_AW-1:0] SW_IO_ADDR = 6'h3F;
endpackage

// File: rtl/sw_arith_flags.sv
// Module sw_arith_flags
// Computes the next carry, zero, negative, overflow and half-carry values
// from the ALU outputs. Each flag has its own enable and keeps its current
// value when that enable is low. Assumes the result MSB is the sign bit.
module sw_arith_flags #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res,
    input  logic              cout,
    input  logic              hcout,
    input  logic              ovf,
    input  logic              en_c,
    input  logic              en_z,
    input  logic              en_n,
    input  logic              en_v,
    input  logic              en_h,
    input  logic              cur_c,
    input  logic              cur_z,
    input  logic              cur_n,
    input  logic              cur_v,
    input  logic              cur_h,
    output logic              nxt_c,
    output logic              nxt_z,
    output logic              nxt_n,
    output logic              nxt_v,
    output logic              nxt_h
);
    localparam int MSB = DATA_W - 1;

    logic res_zero;

    // Zero detect across the whole result
    always_comb res_zero = (res == '0);

    // Per-flag select between new ALU value and held value
    always_comb begin
        nxt_c = en_c ? cout     : cur_c;
        nxt_z = en_z ? res_zero : cur_z;
        nxt_n = en_n ? res[MSB] : cur_n;
        nxt_v = en_v ? ovf      : cur_v;
        nxt_h = en_h ? hcout    : cur_h;
    end
endmodule

// File: rtl/sw_bit_xfer.sv
// Module sw_bit_xfer
// Transfer-bit datapath: picks the next transfer bit for a bit-store and
// forms the bit-load result by replacing one bit of a register with the
// current transfer bit. Assumes bit_sel always addresses an existing bit.
module sw_bit_xfer #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              bst_req,
    input  logic [DATA_W-1:0] bst_src,
    input  logic [DATA_W-1:0] bld_src,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              t_cur,
    output logic              t_nxt,
    output logic [DATA_W-1:0] bld_out
);
    // Next transfer bit: copy of the selected source bit on a store
    always_comb t_nxt = bst_req ? bst_src[bit_sel] : t_cur;

    // Bit-load result, one mux per bit position
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bld
        always_comb bld_out[gi] = (bit_sel == SEL_W'(gi)) ? t_cur : bld_src[gi];
    end

    // R6
    always_comb begin
        bld_sel_chk: assert (bld_out[bit_sel] == t_cur);
    end
endmodule

// File: rtl/status_word_unit.sv
// Module status_word_unit
// Processor status word register. Sources in priority order: an I/O bus
// write at SW_IO_ADDR, then the per-flag ALU updates, bit-store and the
// interrupt enable set/clear (clear beats set). The sign bit is always
// rebuilt as negative XOR overflow. Synchronous active-low reset.
module status_word_unit
    import sw_pkg::*;
#(
    parameter int DATA_W = SW_W,
    parameter logic [IO_AW-1:0] IO_ADDR = SW_IO_ADDR,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_cout,
    input  logic              alu_hcout,
    input  logic              alu_ovf,
    input  logic              upd_c,
    input  logic              upd_z,
    input  logic              upd_n,
    input  logic              upd_v,
    input  logic              upd_h,
    input  logic              bst_req,
    input  logic [DATA_W-1:0] bst_src,
    input  logic [DATA_W-1:0] bld_src,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              int_set,
    input  logic              int_clr,
    input  logic              io_we,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [SW_W-1:0]   io_wdata,
    output logic [SW_W-1:0]   flags,
    output logic [DATA_W-1:0] bld_out
);
    logic [SW_W-1:0] sw_q;
    logic [SW_W-1:0] upd_word;
    logic [SW_W-1:0] bus_word;
    logic            bus_hit;
    logic            nc, nz, nn, nv, nh, nt, ni;

    sw_arith_flags #(.DATA_W(DATA_W)) u_arith (
        .res   (alu_res),
        .cout  (alu_cout),
        .hcout (alu_hcout),
        .ovf   (alu_ovf),
        .en_c  (upd_c),
        .en_z  (upd_z),
        .en_n  (upd_n),
        .en_v  (upd_v),
        .en_h  (upd_h),
        .cur_c (sw_q[POS_C]),
        .cur_z (sw_q[POS_Z]),
        .cur_n (sw_q[POS_N]),
        .cur_v (sw_q[POS_V]),
        .cur_h (sw_q[POS_H]),
        .nxt_c (nc),
        .nxt_z (nz),
        .nxt_n (nn),
        .nxt_v (nv),
        .nxt_h (nh)
    );

    sw_bit_xfer #(.DATA_W(DATA_W)) u_xfer (
        .bst_req (bst_req),
        .bst_src (bst_src),
        .bld_src (bld_src),
        .bit_sel (bit_sel),
        .t_cur   (sw_q[POS_T]),
        .t_nxt   (nt),
        .bld_out (bld_out)
    );

    // Address match for a bus write to this register
    always_comb bus_hit = io_we && (io_addr == IO_ADDR);

    // Interrupt enable: clear wins over set
    always_comb ni = int_clr ? 1'b0 : (int_set ? 1'b1 : sw_q[POS_I]);

    // Word assembled from the individual update paths
    always_comb begin
        upd_word        = '0;
        upd_word[POS_C] = nc;
        upd_word[POS_Z] = nz;
        upd_word[POS_N] = nn;
        upd_word[POS_V] = nv;
        upd_word[POS_S] = nn ^ nv;
        upd_word[POS_H] = nh;
        upd_word[POS_T] = nt;
        upd_word[POS_I] = ni;
    end

    // Word taken from the bus with the sign bit rebuilt
    always_comb begin
        bus_word        = io_wdata;
        bus_word[POS_S] = io_wdata[POS_N] ^ io_wdata[POS_V];
    end

    // Status register with bus write taking priority
    always_ff @(posedge clk) begin
        if (!rst_n)       sw_q <= '0;
        else if (bus_hit) sw_q <= bus_word;
        else              sw_q <= upd_word;
    end

    // Drive the flag byte output
    always_comb flags = sw_q;

    // R2
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags[POS_S] == (flags[POS_N] ^ flags[POS_V]));

    // R8
    bus_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && io_addr == IO_ADDR) |=>
            ({flags[7:5], flags[3:0]} == {$past(io_wdata[7:5]), $past(io_wdata[3:0])}));

    // R7
    int_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !(io_we && io_addr == IO_ADDR)) |=> !flags[POS_I]);

    // R7
    int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_set && !int_clr && !(io_we && io_addr == IO_ADDR)) |=> flags[POS_I]);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_c || upd_z || upd_n || upd_v || upd_h || bst_req || int_set ||
          int_clr || io_we) |=> $stable(flags));

    // R5
    bst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_req && !io_we) |=> flags[POS_T] == $past(bst_src[bit_sel]));
endmodule

// File: tb/status_word_unit_tb.sv
module status_word_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] alu_res = '0;
    logic       alu_cout = 0, alu_hcout = 0, alu_ovf = 0;
    logic       upd_c = 0, upd_z = 0, upd_n = 0, upd_v = 0, upd_h = 0;
    logic       bst_req = 0;
    logic [7:0] bst_src = '0, bld_src = '0;
    logic [2:0] bit_sel = '0;
    logic       int_set = 0, int_clr = 0, io_we = 0;
    logic [5:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] flags, bld_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    status_word_unit u_dut (
        .clk(clk), .rst_n(rst_n), .alu_res(alu_res), .alu_cout(alu_cout),
        .alu_hcout(alu_hcout), .alu_ovf(alu_ovf), .upd_c(upd_c), .upd_z(upd_z),
        .upd_n(upd_n), .upd_v(upd_v), .upd_h(upd_h), .bst_req(bst_req),
        .bst_src(bst_src), .bld_src(bld_src), .bit_sel(bit_sel),
        .int_set(int_set), .int_clr(int_clr), .io_we(io_we), .io_addr(io_addr),
        .io_wdata(io_wdata), .flags(flags), .bld_out(bld_out)
    );

    always #10 clk = ~clk;

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Reference next-state from the requirements
    function automatic logic [7:0] model_next(logic [7:0] cur);
        logic [7:0] n;
        if (io_we && io_addr == 6'h3F) begin
            n = io_wdata;
            n[4] = io_wdata[2] ^ io_wdata[3];
        end else begin
            n = cur;
            if (upd_c) n[0] = alu_cout;
            if (upd_z) n[1] = (alu_res == 8'h00);
            if (upd_n) n[2] = alu_res[7];
            if (upd_v) n[3] = alu_ovf;
            if (upd_h) n[5] = alu_hcout;
            n[4] = n[2] ^ n[3];
            if (bst_req) n[6] = bst_src[bit_sel];
            if (int_clr) n[7] = 1'b0;
            else if (int_set) n[7] = 1'b1;
        end
        return n;
    endfunction

    task automatic idle_inputs();
        alu_res = '0; alu_cout = 0; alu_hcout = 0; alu_ovf = 0;
        upd_c = 0; upd_z = 0; upd_n = 0; upd_v = 0; upd_h = 0;
        bst_req = 0; int_set = 0; int_clr = 0; io_we = 0; io_addr = '0;
        io_wdata = '0;
    endtask

    // Driver: inputs were set after a falling edge; check bit-load, then
    // push the expected word and let the monitor compare it
    task automatic commit(string tag);
        logic [7:0] bexp;
        #1;
        bexp = bld_src;
        bexp[bit_sel] = mdl[6];
        check8({tag, " R6 bld_out"}, bld_out, bexp);
        mdl = model_next(mdl);
        @(posedge clk);
        #1;
        exp_q.push_back(mdl);
        tag_q.push_back(tag);
        idle_inputs();
    endtask

    // Monitor: compare registered flags away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check8(t, flags, e);
        end
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1 reset word", flags, 8'h00);

        // R3 R4: negative result with carry and half-carry
        @(negedge clk);
        alu_res = 8'h80; alu_cout = 1; alu_hcout = 1; alu_ovf = 0;
        {upd_c, upd_z, upd_n, upd_v, upd_h} = 5'b11111;
        commit("R3 R4 neg result");

        // R3: zero result clears N, sets Z; overflow gives S
        @(negedge clk);
        alu_res = 8'h00; alu_ovf = 1;
        upd_z = 1; upd_n = 1; upd_v = 1;
        commit("R3 zero result");

        // R4: only carry enabled, others held
        @(negedge clk);
        alu_res = 8'h7F; alu_cout = 0; alu_hcout = 0; alu_ovf = 0;
        upd_c = 1;
        commit("R4 partial enable");

        // R3: nonzero positive result
        @(negedge clk);
        alu_res = 8'h01; upd_z = 1; upd_n = 1;
        commit("R3 nonzero result");

        // R5: bit-store of a set bit
        @(negedge clk);
        bst_src = 8'h08; bit_sel = 3; bst_req = 1;
        commit("R5 store one");

        // R6: bit-load with T=1 into bit 5
        @(negedge clk);
        bld_src = 8'h00; bit_sel = 5;
        commit("R6 load one");

        // R5: bit-store of a clear bit
        @(negedge clk);
        bst_src = 8'hFE; bit_sel = 0; bst_req = 1;
        commit("R5 store zero");

        // R6: bit-load with T=0 into bit 7
        @(negedge clk);
        bld_src = 8'hFF; bit_sel = 7;
        commit("R6 load zero");

        // R7: set, then clear, then both
        @(negedge clk);
        int_set = 1;
        commit("R7 int set");
        @(negedge clk);
        int_clr = 1;
        commit("R7 int clear");
        @(negedge clk);
        int_set = 1;
        commit("R7 int set again");
        @(negedge clk);
        int_set = 1; int_clr = 1;
        commit("R7 clear wins");

        // R8: bus write, S recomputed (N=1 V=1 -> S=0)
        @(negedge clk);
        io_we = 1; io_addr = 6'h3F; io_wdata = 8'hFF;
        commit("R8 bus write ff");

        // R8: bus write beats simultaneous updates
        @(negedge clk);
        io_we = 1; io_addr = 6'h3F; io_wdata = 8'h14;
        alu_res = 8'h80; alu_cout = 1; {upd_c, upd_z, upd_n, upd_v, upd_h} = 5'b11111;
        bst_req = 1; bst_src = 8'hFF; int_set = 1;
        commit("R8 bus priority");

        // R9: write to another address ignored
        @(negedge clk);
        io_we = 1; io_addr = 6'h3E; io_wdata = 8'hAA;
        commit("R9 other address");

        // R10: idle hold
        @(negedge clk);
        commit("R10 idle hold");

        // R2: sign from V alone via bus write (N=0 V=1)
        @(negedge clk);
        io_we = 1; io_addr = 6'h3F; io_wdata = 8'h08;
        commit("R2 sign rebuild");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule